// File: doc/BRIEF.md
# Data-Flow I/O Sequencer

This block runs the data-movement half of a SIMD training coprocessor. A local register memory is split into banks, one per time-multiplexed data flow. A stream of 32-bit instructions moves words between that memory and two stream queues. An instruction may do four things. It can select a new active data flow. It can send one word of that flow to the result queue. It can pop the head of the input-vector queue into a slot of that flow. It can set a status bit that the host can read.

One instruction enters every clock cycle. Each one passes through a three-stage pipeline: decode, memory read, then commit. When the input queue is empty and a load is asked for, the whole pipeline holds. It also holds when the result queue is full and an output is asked for. No instruction is lost while the pipeline holds. A control input can reverse the byte order of words on both paths, so that hosts of either endianness are supported. The block has no forwarding logic: the code generator must space a load and a read of the same slot.

Top module: `iosq_flow_seq`

## Requirements
- R1: While reset is asserted and right after it, `act_flow` is 0, `user_bit` is 0, and `res_push` and `vec_pop` are low.
- R2: Instruction fields:
  - bit 31 selects a new flow, and bits 30:28 give that flow number;
  - bit 27 enables the output, and bits 26:20 give the output slot;
  - bit 19 enables the load, and bits 18:12 give the load slot;
  - bit 11 enables a write of the user bit, and bit 10 gives its value;
  - bits 9:0 are ignored.
- R3: With both queues ready, one instruction is taken in every cycle in which `instr_valid` is high. The result word of an instruction is pushed in the third cycle after the cycle in which it was taken.
- R4: The flow selection of an instruction takes effect before its own output. The selected flow stays in use, and stays visible on `act_flow`, for later instructions that do not select a flow.
- R5: A load writes the word at the head of the vector queue to memory address flow*128+slot. An output pushes the word at flow*128+slot. The banks of different flows do not overlap.
- R6: When one instruction both outputs and loads the same slot, the output carries the word from before the load.
- R7: An output issued in the instruction directly after a load of the same slot returns the word from before that load. With one instruction between them, it returns the loaded word.
- R8: `user_bit` takes the value given by an instruction that enables the user-bit write. Instructions that do not enable it leave `user_bit` unchanged.
- R9: When a load finds `vec_empty` high, the pipeline holds. At most three instructions are in flight during the hold, and the queue is never popped while it is empty. When the hold ends, every instruction completes once, in order.
- R10: When an output finds `res_full` high, the pipeline holds in the same way. Nothing is pushed while `res_full` is high, and no result is lost or repeated.
- R11: With `swap_en` high, loaded words are stored byte-reversed and output words are sent byte-reversed. With `swap_en` low, words pass through unchanged.
- R12: A flow field whose select bit is clear has no effect, and neither does a slot field whose enable bit is clear. Such an instruction pops no vector word, pushes no result, and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| swap_en | input | 1 | Reverses the byte order of vector and result words |
| instr_valid | input | 1 | Instruction queue holds a word |
| instr_data | input | 32 | Head of the instruction queue |
| instr_pop | output | 1 | Takes the head instruction |
| vec_empty | input | 1 | Vector queue is empty |
| vec_data | input | 32 | Head of the vector queue |
| vec_pop | output | 1 | Takes the head vector word |
| res_full | input | 1 | Result queue cannot accept a word |
| res_data | output | 32 | Word pushed to the result queue |
| res_push | output | 1 | Pushes `res_data` |
| act_flow | output | 3 | Active data-flow number |
| user_bit | output | 1 | Status bit set by instructions |

## Verification
Two functions can fall in the same cycle. The first is the memory write of one instruction's load. The second is the memory read for the output of the next instruction. The bench provokes this in two ways. It issues a load of a slot directly followed by an output of that slot. It also issues single instructions that both load and output the same slot. In each case it expects the word from before the load. A later output spaced one instruction apart must return the new word. The expected words come from an ordered model of the instruction stream kept in the bench. This model applies a pending load only after the next instruction's read, and it also gives the expected results for the stall and byte-swap runs.

// File: rtl/iosq_pkg.sv
package iosq_pkg;

   // Width of one sequencer instruction word.
   localparam int unsigned IW = 32;

   // Field positions; the code generator encodes against these.
   localparam int unsigned B_NF_EN    = 31;
   localparam int unsigned B_FLOW_HI  = 30;
   localparam int unsigned B_OUT_EN   = 27;
   localparam int unsigned B_A0_HI    = 26;
   localparam int unsigned B_LD_EN    = 19;
   localparam int unsigned B_A3_HI    = 18;
   localparam int unsigned B_UB_WE    = 11;
   localparam int unsigned B_UB_VAL   = 10;

   // Room reserved in the word for the flow and slot fields.
   localparam int unsigned FLOW_FIELD_W = 3;
   localparam int unsigned SLOT_FIELD_W = 7;

   typedef struct packed {
      logic nf_en;
      logic out_en;
      logic ld_en;
      logic ub_we;
      logic ub_val;
   } iosq_ctl_t;

   function automatic iosq_ctl_t iosq_ctl(input logic [IW-1:0] w);
      iosq_ctl_t c;
      c.nf_en  = w[B_NF_EN];
      c.out_en = w[B_OUT_EN];
      c.ld_en  = w[B_LD_EN];
      c.ub_we  = w[B_UB_WE];
      c.ub_val = w[B_UB_VAL];
      return c;
   endfunction

endpackage

// File: rtl/iosq_mem.sv
module iosq_mem #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AW     = 10
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DATA_W-1:0] store [DEPTH];

   // One read and one write port. A read that hits the address being
   // written in the same edge returns the old word.
   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
      if (rd_en) rd_data <= store[rd_addr];
   end

endmodule

// File: rtl/iosq_bswap.sv
module iosq_bswap #(
   parameter int unsigned DATA_W = 32,
   parameter bit          ENABLE = 1'b1
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int unsigned NBYTES = DATA_W / 8;

   generate
      if (ENABLE) begin : g_swap
         logic [DATA_W-1:0] rev;
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign rev[8*b +: 8] = din[DATA_W-8*(b+1) +: 8];
         end
         assign dout = swap ? rev : din;
      end else begin : g_pass
         logic unused_swap;
         assign unused_swap = swap;
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/iosq_flow_seq.sv
module iosq_flow_seq
   import iosq_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FLOWS  = 8,
   parameter int unsigned FLOW_WORDS = 128,
   parameter bit          SWAP_EN    = 1'b1,
   localparam int unsigned FLOW_W    = $clog2(NUM_FLOWS),
   localparam int unsigned SLOT_W    = $clog2(FLOW_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              swap_en,
   input  logic              instr_valid,
   input  logic [IW-1:0]     instr_data,
   output logic              instr_pop,
   input  logic              vec_empty,
   input  logic [DATA_W-1:0] vec_data,
   output logic              vec_pop,
   input  logic              res_full,
   output logic [DATA_W-1:0] res_data,
   output logic              res_push,
   output logic [FLOW_W-1:0] act_flow,
   output logic              user_bit
);

   localparam int unsigned MEM_AW = FLOW_W + SLOT_W;

   // ---------------- elaboration checks ----------------
   generate
      if (FLOW_W < 1 || FLOW_W > FLOW_FIELD_W || (1 << FLOW_W) != NUM_FLOWS) begin : g_bad_flows
         $error("NUM_FLOWS must be a power of two from 2 to 8");
      end
      if (SLOT_W < 1 || SLOT_W > SLOT_FIELD_W || (1 << SLOT_W) != FLOW_WORDS) begin : g_bad_words
         $error("FLOW_WORDS must be a power of two from 2 to 128");
      end
      if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
   endgenerate

   typedef struct packed {
      iosq_ctl_t         ctl;
      logic [FLOW_W-1:0] flow;
      logic [SLOT_W-1:0] a0;
      logic [SLOT_W-1:0] a3;
   } dec_t;

   // ---------------- decode of the incoming word ----------------
   dec_t dec_in;
   logic unused_instr;

   always_comb begin
      dec_in.ctl  = iosq_ctl(instr_data);
      dec_in.flow = instr_data[B_FLOW_HI -: FLOW_W];
      dec_in.a0   = instr_data[B_A0_HI -: SLOT_W];
      dec_in.a3   = instr_data[B_A3_HI -: SLOT_W];
   end
   assign unused_instr = ^instr_data;

   // ---------------- pipeline state ----------------
   logic              s1_v, s2_v, s3_v;
   dec_t              s1, s2;
   logic              s3_out, s3_ld, s3_ubwe, s3_ubv;
   logic [MEM_AW-1:0] s3_addr;
   logic [FLOW_W-1:0] flow_q;
   logic              user_q;

   logic              s3_blk, adv;
   logic [FLOW_W-1:0] eff_flow;
   logic              rd_en, wr_en;
   logic [MEM_AW-1:0] rd_addr;
   logic [DATA_W-1:0] mem_rd, vec_sw;

   // The commit stage is the only place that waits on the queues;
   // when it cannot finish, every stage holds.
   assign s3_blk  = s3_v & ((s3_out & res_full) | (s3_ld & vec_empty));
   assign adv     = ~s3_blk;

   // Flow selection precedes the output read of the same instruction.
   assign eff_flow = (s2_v && s2.ctl.nf_en) ? s2.flow : flow_q;
   assign rd_en    = s2_v & s2.ctl.out_en & adv;
   assign rd_addr  = {eff_flow, s2.a0};

   assign wr_en     = s3_v & s3_ld & adv;
   assign vec_pop   = wr_en;
   assign res_push  = s3_v & s3_out & adv;
   assign instr_pop = instr_valid & adv;
   assign act_flow  = flow_q;
   assign user_bit  = user_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v   <= 1'b0;
         s2_v   <= 1'b0;
         s3_v   <= 1'b0;
         flow_q <= '0;
         user_q <= 1'b0;
      end else if (adv) begin
         s1_v <= instr_valid;
         s2_v <= s1_v;
         s3_v <= s2_v;
         if (s2_v) flow_q <= eff_flow;
         if (s3_v && s3_ubwe) user_q <= s3_ubv;
      end
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         s1      <= dec_in;
         s2      <= s1;
         s3_out  <= s2.ctl.out_en;
         s3_ld   <= s2.ctl.ld_en;
         s3_ubwe <= s2.ctl.ub_we;
         s3_ubv  <= s2.ctl.ub_val;
         s3_addr <= {eff_flow, s2.a3};
      end
   end

   // ---------------- datapath ----------------
   iosq_bswap #(.DATA_W(DATA_W), .ENABLE(SWAP_EN)) i_swap_in (
      .swap (swap_en),
      .din  (vec_data),
      .dout (vec_sw)
   );

   iosq_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) i_mem (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (mem_rd),
      .wr_en   (wr_en),
      .wr_addr (s3_addr),
      .wr_data (vec_sw)
   );

   iosq_bswap #(.DATA_W(DATA_W), .ENABLE(SWAP_EN)) i_swap_out (
      .swap (swap_en),
      .din  (mem_rd),
      .dout (res_data)
   );

   // ---------------- assertions ----------------
   p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_push |-> !res_full);

   p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_pop |-> !vec_empty);

   p_take_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_pop |-> instr_valid);

   p_flow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(act_flow));

   p_user_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s3_blk |=> $stable(user_bit));

   p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_v && s3_out && !adv) |=> $stable(mem_rd));

endmodule

// File: tb/test_iosq_flow_seq.sv
module test_iosq_flow_seq;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        swap_en = 1'b0;
   logic        instr_valid, instr_pop;
   logic [31:0] instr_data;
   logic        vec_empty, vec_pop;
   logic [31:0] vec_data;
   logic        res_full, res_push;
   logic [31:0] res_data;
   logic [2:0]  act_flow;
   logic        user_bit;

   always #4 clk = ~clk;

   iosq_flow_seq i_iosq_flow_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .swap_en     (swap_en),
      .instr_valid (instr_valid),
      .instr_data  (instr_data),
      .instr_pop   (instr_pop),
      .vec_empty   (vec_empty),
      .vec_data    (vec_data),
      .vec_pop     (vec_pop),
      .res_full    (res_full),
      .res_data    (res_data),
      .res_push    (res_push),
      .act_flow    (act_flow),
      .user_bit    (user_bit)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // queue models
   logic [31:0] iq [0:511];
   logic [31:0] vq [0:511];
   logic [31:0] rq [0:511];
   int pop_cyc [0:511];
   int push_cyc [0:511];
   int iq_n = 0, iq_rd = 0, vq_n = 0, vq_rd = 0, rq_n = 0;
   bit vec_block = 0, res_block = 0;
   int cyc = 0, win_pops = 0;

   assign instr_valid = (iq_rd < iq_n);
   assign instr_data  = iq[iq_rd];
   assign vec_empty   = vec_block || (vq_rd >= vq_n);
   assign vec_data    = vq[vq_rd];
   assign res_full    = res_block;

   // reference model state
   logic [31:0] mm [0:1023];
   logic [31:0] exp_q [0:511];
   int exp_n = 0, m_vrd = 0, m_flow = 0, pend_a = 0;
   bit m_user = 0, pend = 0;
   logic [31:0] pend_d;
   int b_iq, b_rq, b_exp;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bsw(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [31:0] sw(input logic [31:0] w);
      return swap_en ? bsw(w) : w;
   endfunction

   function automatic logic [31:0] enc(input bit nf, input int fl, input bit oe, input int a0,
                                       input bit ld, input int a3, input bit uwe, input bit uv);
      logic [31:0] w;
      w = '0;
      w[31] = nf; w[30:28] = fl[2:0];
      w[27] = oe; w[26:20] = a0[6:0];
      w[19] = ld; w[18:12] = a3[6:0];
      w[11] = uwe; w[10] = uv;
      return w;
   endfunction

   task automatic put_i(input logic [31:0] w);
      iq[iq_n] = w; iq_n++;
   endtask

   task automatic put_v(input logic [31:0] w);
      vq[vq_n] = w; vq_n++;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // handshake observer: samples at the falling edge, commits after the rise
   initial begin
      forever begin
         bit p_i, p_v, p_r;
         @(negedge clk);
         p_i = instr_pop; p_v = vec_pop; p_r = res_push;
         if (p_r) begin
            if (res_full) begin
               errors++; checks++;
               $display("FAIL R10 push while full: actual 1 expected 0");
            end
            rq[rq_n] = res_data; push_cyc[rq_n] = cyc; rq_n++;
         end
         if (p_v && vec_empty) begin
            errors++; checks++;
            $display("FAIL R9 pop while empty: actual 1 expected 0");
         end
         if (p_i) begin pop_cyc[iq_rd] = cyc; win_pops++; end
         @(posedge clk);
         #1;
         cyc++;
         if (p_i) iq_rd++;
         if (p_v) vq_rd++;
      end
   end

   // ordered model: a load lands after the next instruction's read
   task automatic model_batch(input int from);
      for (int j = from; j < iq_n; j++) begin
         logic [31:0] w;
         w = iq[j];
         if (w[31]) m_flow = int'(w[30:28]);
         if (w[27]) begin
            exp_q[exp_n] = sw(mm[m_flow*128 + int'(w[26:20])]);
            exp_n++;
         end
         if (pend) begin mm[pend_a] = pend_d; pend = 0; end
         if (w[19]) begin
            pend = 1; pend_a = m_flow*128 + int'(w[18:12]);
            pend_d = sw(vq[m_vrd]); m_vrd++;
         end
         if (w[11]) m_user = w[10];
      end
      if (pend) begin mm[pend_a] = pend_d; pend = 0; end
   endtask

   task automatic begin_batch();
      b_iq = iq_n; b_rq = rq_n; b_exp = exp_n; win_pops = 0;
   endtask

   task automatic end_batch(input string tag);
      int got, want;
      model_batch(b_iq);
      while (iq_rd < iq_n) tick(1);
      tick(5);
      got = rq_n - b_rq; want = exp_n - b_exp;
      chk(tag, "result count", got, want);
      for (int i = 0; i < got && i < want; i++)
         chk(tag, "result word", rq[b_rq+i], exp_q[b_exp+i]);
      chk("R12", "vector words taken", vq_rd, m_vrd);
      chk("R4", "active flow", 32'(act_flow), m_flow);
      chk("R8", "user bit", 32'(user_bit), 32'(m_user));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R3 watchdog: actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      tick(3);
      chk("R1", "flow in reset", 32'(act_flow), 0);
      chk("R1", "user in reset", 32'(user_bit), 0);
      chk("R1", "push in reset", 32'(res_push), 0);
      chk("R1", "pop in reset", 32'(vec_pop), 0);
      rst_n = 1'b1;
      tick(2);
      chk("R1", "flow after reset", 32'(act_flow), 0);
      chk("R1", "user after reset", 32'(user_bit), 0);

      // R2 R5 sweep: four slots in every flow, loaded then read back
      begin_batch();
      for (int f = 0; f < 8; f++)
         for (int k = 0; k < 4; k++) begin
            put_v({8'hC3, 8'(f), 8'(k*37+f), 8'(k)});
            put_i(enc(1, f, 0, 0, 1, k*37+f, 0, 0));
         end
      for (int f = 0; f < 8; f++)
         for (int k = 0; k < 4; k++)
            put_i(enc(k == 0, f, 1, k*37+f, 0, 0, 0, 0)); // R4 sticky flow
      end_batch("R2 R5");
      chk("R3", "back-to-back acceptance", pop_cyc[b_iq+63] - pop_cyc[b_iq], 63);
      chk("R3", "output latency", push_cyc[b_rq] - pop_cyc[b_iq+32], 3);

      // R6: same instruction outputs and loads slot 2 of flow 2
      begin_batch();
      put_v(32'hD00D_0006);
      put_i(enc(1, 2, 1, 2, 1, 2, 0, 0));
      put_i(32'h0000_0000);
      put_i(enc(0, 0, 1, 2, 0, 0, 0, 0));
      end_batch("R6");

      // R7: load slot 39 then read it at once, then again one later
      begin_batch();
      put_v(32'hBEEF_0007);
      put_i(enc(0, 0, 0, 0, 1, 39, 0, 0));
      put_i(enc(0, 0, 1, 39, 0, 0, 0, 0));
      put_i(enc(0, 0, 1, 39, 0, 0, 0, 0));
      end_batch("R7");

      // R8 user bit set, kept, cleared
      begin_batch();
      put_i(enc(0, 0, 0, 0, 0, 0, 1, 1));
      end_batch("R8");
      begin_batch();
      put_i(enc(0, 0, 1, 2, 0, 0, 0, 0));
      end_batch("R8");
      begin_batch();
      put_i(enc(0, 0, 0, 0, 0, 0, 1, 0));
      end_batch("R8");

      // R11 byte swap on input, then on output
      swap_en = 1'b1;
      begin_batch();
      put_v(32'h1122_3344);
      put_i(enc(1, 5, 0, 0, 1, 100, 0, 0));
      end_batch("R11");
      swap_en = 1'b0;
      begin_batch();
      put_i(enc(0, 0, 1, 100, 0, 0, 0, 0));
      end_batch("R11");
      chk("R11", "stored reversed", rq[rq_n-1], 32'h4433_2211);
      swap_en = 1'b1;
      begin_batch();
      put_i(enc(0, 0, 1, 100, 0, 0, 0, 0));
      put_i(enc(1, 0, 1, 37, 0, 0, 0, 0));
      end_batch("R11");
      swap_en = 1'b0;

      // R9 vector queue stalls
      vec_block = 1;
      begin_batch();
      put_i(enc(1, 3, 1, 3, 1, 60, 0, 0));
      for (int s = 61; s < 66; s++) put_i(enc(0, 0, 0, 0, 1, s, 0, 0));
      for (int s = 0; s < 6; s++) put_v(32'hE000_0000 + 32'(s*3 + 1));
      tick(12);
      chk("R9", "instructions in flight", win_pops, 3);
      chk("R9", "no result during hold", rq_n - b_rq, 0);
      for (int c = 0; c < 15; c++) begin vec_block = (c % 3 != 2); tick(1); end
      vec_block = 0;
      end_batch("R9");
      begin_batch();
      for (int s = 60; s < 66; s++) put_i(enc(0, 0, 1, s, 0, 0, 0, 0));
      end_batch("R9");

      // R10 result queue full
      res_block = 1;
      begin_batch();
      put_i(enc(1, 0, 1, 0, 0, 0, 0, 0));
      put_i(enc(0, 0, 1, 37, 0, 0, 0, 0));
      put_i(enc(0, 0, 1, 74, 0, 0, 0, 0));
      put_i(enc(0, 0, 1, 111, 0, 0, 0, 0));
      put_i(enc(1, 1, 1, 1, 0, 0, 0, 0));
      put_i(enc(0, 0, 1, 38, 0, 0, 0, 0));
      tick(12);
      chk("R10", "instructions in flight", win_pops, 3);
      chk("R10", "no push while full", rq_n - b_rq, 0);
      for (int c = 0; c < 15; c++) begin res_block = (c % 2 == 0); tick(1); end
      res_block = 0;
      end_batch("R10");

      // R12 fields without their enable bits have no effect
      put_v(32'h5555_AAAA);
      begin_batch();
      put_i(enc(0, 6, 0, 7, 0, 1, 0, 1));
      end_batch("R12");
      chk("R12", "no result", rq_n - b_rq, 0);
      begin_batch();
      put_i(enc(0, 0, 1, 1, 0, 0, 0, 0));
      end_batch("R12");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule